// File: doc/BRIEF.md
# H-Bridge Control and Fault Logic

This block is the digital control core of a full-bridge motor driver made of two half-bridges, A and B. Each half-bridge has a high-side switch and a gate enable for an external low-side switch. Two direction inputs, one per side, select the bridge mode: drive in either direction, brake to the supply or brake to ground. A per-side enable input takes a half-bridge out of service. A PWM input chops only the low-side gates. Analog sensing happens outside the block and reaches it as digital flags: over-temperature, low-side saturation, undervoltage, test mode and load-open.

On an over-temperature or saturation flag, the affected half-bridge latches itself off and asserts its diagnostic pull-down. That pull-down drives the open-drain half of the side's shared enable/diagnostic line. The latch clears only on a fresh rising edge of that side's direction input. While one side is latched, the other side keeps working. A dead-time interlock holds each low-side gate off for a set number of cycles after the high side of the same side turns off. In test mode only the high sides can be driven, so load continuity can be checked, and a load-open flag is reported on that side's diagnostic output.

Top module: `hbridge_ctrl`

## Requirements
- R1: With its enable high and no fault, a side turns on its high side when its direction input is 1, and its low-side gate when the input is 0. With its enable low, both of that side's outputs are off.
- R2: Per-side control gives the combined modes.
  - Both inputs 1: both high sides on.
  - A=1, B=0: high A and low B on.
  - A=0, B=1: high B and low A on.
  - Both inputs 0: both low gates on.
  - Both enables low: all outputs off.
  - One enable high: only that side is driven.
- R3: PWM=0 forces both low-side gates off. The high sides ignore PWM. When PWM returns to 1, the gates follow the inputs again.
- R4: On each side, a low-side gate turns on no earlier than DEAD_CYC+1 cycles after that side's high side turns off. It turns on exactly then if it is requested throughout. After reset the dead time counts as already elapsed.
- R5: On a given side, the high side and the low-side gate are never on in the same cycle. A change from low gate to high side leaves at least one cycle with both off.
- R6: An over-temperature or saturation flag on a side latches that side off, with both of its outputs off. The side's diagnostic output is high while the latch is set.
- R7: A side's latch clears only on a rising edge of that side's direction input while no fault flag of that side is active. Toggling the enable does not clear it. The other side keeps operating normally meanwhile.
- R8: In test mode both low-side gates are off and the high sides follow the inputs. A side's diagnostic output is high while test mode and that side's load-open flag are both asserted.
- R9: While undervoltage is asserted, all four outputs are off. Nothing latches, so normal operation resumes once it drops.
- R10: Every input passes through a two-flop synchronizer into registered outputs. A high-side output responds on the third rising clock edge after an input change.
- R11: During reset all outputs, including the diagnostics, are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_a_i | input | 1 | Direction input, side A |
| in_b_i | input | 1 | Direction input, side B |
| pwm_i | input | 1 | Low-side chopping input, 0 = gates off |
| en_a_i | input | 1 | Sensed level of enable/diag line A |
| en_b_i | input | 1 | Sensed level of enable/diag line B |
| ot_a_i | input | 1 | Over-temperature flag, high side A |
| ot_b_i | input | 1 | Over-temperature flag, high side B |
| sat_a_i | input | 1 | Saturation flag, low-side switch A |
| sat_b_i | input | 1 | Saturation flag, low-side switch B |
| uv_i | input | 1 | Undervoltage flag |
| test_i | input | 1 | Load-continuity test mode |
| open_a_i | input | 1 | Load-open flag for output A |
| open_b_i | input | 1 | Load-open flag for output B |
| hs_a_o | output | 1 | High-side enable A |
| hs_b_o | output | 1 | High-side enable B |
| ls_a_o | output | 1 | Low-side gate enable A |
| ls_b_o | output | 1 | Low-side gate enable B |
| diag_a_o | output | 1 | Pull-down request for line A |
| diag_b_o | output | 1 | Pull-down request for line B |

## Verification
A high-side output answers on the third rising edge after an input change, and the latency check samples at exactly the second and third edges. A low-side gate answers a further DEAD_CYC+1 edges after its own high side falls, so the dead-time check counts edges from the observed high-side fall to the low-side rise. Fault, undervoltage and diagnostic results need three edges. The bench waits at least four edges before those checks, and at least DEAD_CYC+10 edges before any check that may involve a dead-time wait. All inputs are driven and all outputs sampled on falling edges.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef struct packed {
    logic in;
    logic en;
    logic ot;
    logic sat;
    logic open;
  } leg_in_t;

  typedef struct packed {
    logic hs;
    logic ls;
    logic diag;
  } leg_out_t;

  localparam int unsigned LEG_W  = $bits(leg_in_t);
  localparam int unsigned N_LEGS = 2;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 1000
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  leg_in_t  leg_i,
  input  logic     pwm_i,
  input  logic     uv_i,
  input  logic     test_i,
  output leg_out_t leg_o
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DT_MAX = CW'(DEAD_CYC);

  logic in_q, in_rise, flt_now, fault_q;
  logic active, hs_req, ls_req, dt_done;
  logic hs_q, ls_q, tdiag_q;
  logic [CW-1:0] dt_q;

  assign in_rise = leg_i.in & ~in_q;
  assign flt_now = leg_i.ot | leg_i.sat;

  // fault latch: set wins over re-arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      in_q <= leg_i.in;
      if (flt_now)      fault_q <= 1'b1;
      else if (in_rise) fault_q <= 1'b0;
    end
  end

  assign active  = leg_i.en & ~fault_q & ~flt_now & ~uv_i;
  assign hs_req  = active & leg_i.in;
  assign ls_req  = active & ~leg_i.in & pwm_i & ~test_i;
  assign dt_done = (dt_q == DT_MAX);

  // dead-time counter: restarts while high side is on, saturates at DT_MAX
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dt_q <= DT_MAX;
    else if (hs_q)     dt_q <= '0;
    else if (!dt_done) dt_q <= dt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
      tdiag_q <= 1'b0;
    end else begin
      hs_q    <= hs_req & ~ls_q;
      ls_q    <= ls_req & dt_done & ~hs_q;
      tdiag_q <= test_i & leg_i.open;
    end
  end

  assign leg_o.hs   = hs_q;
  assign leg_o.ls   = ls_q;
  assign leg_o.diag = fault_q | tdiag_q;

  AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_q && ls_q)); // R5
  AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_q) |=> !ls_q); // R4
  AST_PWM_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> !ls_q); // R3
  AST_FAULT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |=> (!hs_q && !ls_q)); // R6
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !in_rise) |=> fault_q); // R7
  AST_UV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> (!hs_q && !ls_q)); // R9
  AST_TEST_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> !ls_q); // R8
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_a_i,
  input  logic in_b_i,
  input  logic pwm_i,
  input  logic en_a_i,
  input  logic en_b_i,
  input  logic ot_a_i,
  input  logic ot_b_i,
  input  logic sat_a_i,
  input  logic sat_b_i,
  input  logic uv_i,
  input  logic test_i,
  input  logic open_a_i,
  input  logic open_b_i,
  output logic hs_a_o,
  output logic hs_b_o,
  output logic ls_a_o,
  output logic ls_b_o,
  output logic diag_a_o,
  output logic diag_b_o
);
  localparam int unsigned NSYNC = N_LEGS * LEG_W + 3;

  logic [NSYNC-1:0] raw, syn;
  leg_out_t leg_out [N_LEGS];

  assign raw = {pwm_i, uv_i, test_i,
                in_b_i, en_b_i, ot_b_i, sat_b_i, open_b_i,
                in_a_i, en_a_i, ot_a_i, sat_a_i, open_a_i};

  hb_sync #(.W(NSYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .leg_i (leg_in_t'(syn[g*LEG_W +: LEG_W])),
      .pwm_i (syn[NSYNC-1]),
      .uv_i  (syn[NSYNC-2]),
      .test_i(syn[NSYNC-3]),
      .leg_o (leg_out[g])
    );
  end

  assign hs_a_o   = leg_out[0].hs;
  assign ls_a_o   = leg_out[0].ls;
  assign diag_a_o = leg_out[0].diag;
  assign hs_b_o   = leg_out[1].hs;
  assign ls_b_o   = leg_out[1].ls;
  assign diag_b_o = leg_out[1].diag;
endmodule

// File: tb/hbridge_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_ctrl_bench;
  localparam int DT = 6;
  localparam int NV = 13;
  // {in_a,in_b,en_a,en_b,pwm,test, hs_a,hs_b,ls_a,ls_b}
  localparam logic [9:0] VEC [NV] = '{
    10'b111110_1100, 10'b101110_1001, 10'b011110_0110, 10'b001110_0011,
    10'b001100_0000, 10'b111100_1100, 10'b100010_0000, 10'b101010_1000,
    10'b001010_0010, 10'b110110_0100, 10'b000110_0001, 10'b101111_1000,
    10'b001111_0000};

  logic clk = 0, rst_ni = 0;
  logic in_a = 0, in_b = 0, pwm = 0, en_a = 0, en_b = 0;
  logic ot_a = 0, ot_b = 0, sat_a = 0, sat_b = 0, uv = 0, test = 0;
  logic open_a = 0, open_b = 0;
  logic hs_a, hs_b, ls_a, ls_b, diag_a, diag_b;
  int n_chk = 0, n_bad = 0, overlap = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hbridge_ctrl #(.DEAD_CYC(DT)) u_hbridge_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .in_a_i(in_a), .in_b_i(in_b), .pwm_i(pwm),
    .en_a_i(en_a), .en_b_i(en_b), .ot_a_i(ot_a), .ot_b_i(ot_b),
    .sat_a_i(sat_a), .sat_b_i(sat_b), .uv_i(uv), .test_i(test),
    .open_a_i(open_a), .open_b_i(open_b), .hs_a_o(hs_a), .hs_b_o(hs_b),
    .ls_a_o(ls_a), .ls_b_o(ls_b), .diag_a_o(diag_a), .diag_b_o(diag_b));

  wire [3:0] obs = {hs_a, hs_b, ls_a, ls_b};
  wire [1:0] dg  = {diag_a, diag_b};

  always @(negedge clk)
    if (rst_ni && ((hs_a && ls_a) || (hs_b && ls_b))) overlap++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    if (i == 4 || i == 5) return "R3";
    if (i >= 11) return "R8";
    return "R2";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R11 reset outputs", {2'b0, dg, obs}, 8'h00);
    rst_ni = 1;
    pwm = 1;
    for (int i = 0; i < NV; i++) begin
      {in_a, in_b, en_a, en_b, pwm, test} = VEC[i][9:4];
      tick(DT + 10);
      check(row_tag(i), {4'b0, obs}, {4'b0, VEC[i][3:0]});
    end
    test = 0;

    // R10 / R1: latency of high side from enable
    en_a = 0; en_b = 0; in_a = 1; in_b = 0; pwm = 1;
    tick(DT + 10);
    en_a = 1;
    tick(2);
    check("R10 hs_a after 2 edges", {7'b0, hs_a}, 8'd0);
    tick(1);
    check("R10 R1 hs_a after 3 edges", {7'b0, hs_a}, 8'd1);

    // R4: dead time from hs fall to ls rise
    in_a = 0;
    begin
      int n = 0, m = 0;
      while (hs_a && n < 20) begin tick(1); n++; end
      while (!ls_a && m < 200) begin tick(1); m++; end
      check("R4 dead-time cycles", 8'(m), 8'(DT + 1));
    end
    check("R1 low gate on for in=0", {4'b0, obs}, 8'b0010);
    in_a = 1;
    tick(DT);
    check("R5 ls to hs change", {4'b0, obs}, 8'b1000);

    // R6/R7 over-temperature on A in clockwise mode
    en_b = 1; in_b = 0;
    tick(DT + 10);
    check("R2 cw before fault", {4'b0, obs}, 8'b1001);
    ot_a = 1; tick(2); ot_a = 0; tick(4);
    check("R6 A latched off", {2'b0, dg, obs}, {2'b0, 2'b10, 4'b0001});
    en_a = 0; tick(4); en_a = 1; tick(4);
    check("R7 enable toggle no clear", {2'b0, dg, obs}, {2'b0, 2'b10, 4'b0001});
    in_a = 0; tick(DT + 10);
    check("R7 still latched in=0", {2'b0, dg, obs}, {2'b0, 2'b10, 4'b0001});
    in_a = 1; tick(5);
    check("R7 rearm on rise", {2'b0, dg, obs}, {2'b0, 2'b00, 4'b1001});

    // R7 rise while flag held does not clear
    ot_a = 1; tick(5); in_a = 0; tick(4); in_a = 1; tick(5);
    check("R7 rise with flag held", {7'b0, diag_a}, 8'd1);
    ot_a = 0; tick(4);
    check("R7 flag drop alone", {7'b0, diag_a}, 8'd1);
    in_a = 0; tick(4); in_a = 1; tick(5);
    check("R7 clear after flag gone", {2'b0, dg, obs}, {2'b0, 2'b00, 4'b1001});

    // R6/R7 saturation on B
    sat_b = 1; tick(2); sat_b = 0; tick(4);
    check("R6 B sat latched", {2'b0, dg, obs}, {2'b0, 2'b01, 4'b1000});
    in_b = 1; tick(5);
    check("R7 B rearm", {2'b0, dg, obs}, {2'b0, 2'b00, 4'b1100});
    in_b = 0; tick(DT + 10);
    check("R7 B low gate back", {4'b0, obs}, 8'b1001);

    // R9 undervoltage
    uv = 1; tick(4);
    check("R9 uv all off", {4'b0, obs}, 8'b0000);
    uv = 0; tick(DT + 10);
    check("R9 uv recovery", {2'b0, dg, obs}, {2'b0, 2'b00, 4'b1001});

    // R8 test-mode load-open report
    test = 1; open_b = 1; tick(4);
    check("R8 open B diag", {2'b0, dg, obs}, {2'b0, 2'b01, 4'b1000});
    open_b = 0; open_a = 1; tick(4);
    check("R8 open A diag", {6'b0, dg}, 8'b10);
    open_a = 0; tick(4);
    check("R8 diag release", {6'b0, dg}, 8'b00);
    test = 0;

    check("R5 no overlap seen", 8'(overlap), 8'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule